// File: doc/BRIEF.md
# Denormal Operand Handling Sequencer

This block sits in front of a floating-point adder or multiplier and decides what happens to subnormal single-precision operands. One request carries two 32-bit operands, an add/multiply select and, per operand, a flag saying that the value is already held in the wide internal format. A mode pin picks between two policies. Flush-to-zero treats every subnormal input as a signed zero at no time cost. Full IEEE handling normalizes each subnormal input in a cycle of its own, after one entry cycle, while the instruction is held by `busy`.

The operands leave in an expanded layout `{sign, exp, mant}`: `sign` at bit 34, a signed 10-bit biased exponent at bits 33:24 and a 24-bit mantissa with an explicit leading bit at bits 23:0. They are valid in the cycle in which `done` pulses and stay unchanged until the next request is accepted. A separate combinational result path replaces subnormal results with signed zero when flush mode is on.

Requests use a valid/ready pair. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low for every stall cycle, so a valid held during a stall is simply not taken. There is no downstream back-pressure: `done` is a one-cycle pulse.

Top module: `denorm_seq`

## Requirements
- R1: In flush mode (`ftz_mode`=1), a subnormal input (exponent field 0, fraction non-zero) is presented as `{sign, 10'd0, 24'd0}`, keeping its sign.
- R2: In flush mode, `done` pulses in the first cycle after acceptance, and `busy` stays low throughout.
- R3: `res_out` equals `res_in` when `ftz_mode`=0. When `ftz_mode`=1, a result word with exponent field 0 leaves as `{res_in[31], 31'b0}` and any other result word passes unchanged.
- R4: In IEEE mode, with n counted subnormal inputs (n = 1 or 2), `busy` is high for exactly 1+n cycles after acceptance and `done` pulses in the cycle after that.
- R5: In IEEE mode, a counted subnormal input with fraction f is presented normalized. The mantissa is f shifted left until its leading one reaches bit 23, and the exponent equals 1 minus the number of shifts (a value from 0 down to -22).
- R6: For an add (`op_mul`=0), a subnormal operand whose extended flag is set is not counted. It is presented unnormalized as `{sign, 10'd1, {1'b0, f}}`. For a multiply, the flag has no effect.
- R7: A true zero (exponent 0, fraction 0) is presented as `{sign, 0, 0}` and adds no cycles. A request with no counted subnormal completes as in R2.
- R8: An operand with a non-zero exponent field e and fraction f is presented as `{sign, {2'b00, e}, {1'b1, f}}`.
- R9: `in_ready` is low while `busy` is high. A request offered during that time is ignored and does not alter the operands of the request in flight.
- R10: When both operands are counted, the first operand is normalized before the second, and `busy` stays high for 3 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Request can be taken this cycle |
| opa_word | input | 32 | First operand, single-precision |
| opb_word | input | 32 | Second operand, single-precision |
| op_mul | input | 1 | 1 = multiply, 0 = add |
| opa_ext | input | 1 | First operand already in extended form |
| opb_ext | input | 1 | Second operand already in extended form |
| ftz_mode | input | 1 | 1 = flush-to-zero, 0 = IEEE handling |
| busy | output | 1 | Instruction stall in progress |
| done | output | 1 | One-cycle completion pulse |
| opa_out | output | 35 | First operand for the arithmetic unit |
| opb_out | output | 35 | Second operand for the arithmetic unit |
| res_in | input | 32 | Result word from the arithmetic unit |
| res_out | output | 32 | Filtered result word |

## Verification
After an accepting edge, `done` and the operand outputs are due one cycle later when nothing is counted, and 2+n cycles later when n subnormals are counted. `busy` covers exactly the 1+n cycles in between. `res_out` is due in the same cycle as `res_in`. The bench advances a behavioural countdown on each rising edge and compares `busy`, `done`, `in_ready` and `res_out` on every falling edge. It compares the operands only in a cycle where the model expects `done`, so every value is read in the cycle in which it is due.

// File: rtl/denorm_pkg.sv
package denorm_pkg;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;

  typedef enum logic [1:0] {
    S_IDLE,
    S_ENTRY,
    S_NORM_A,
    S_NORM_B
  } seq_state_t;
endpackage

// File: rtl/dn_operand_prep.sv
// Classifies one input word and builds its single-cycle presentation.
module dn_operand_prep #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int OEXP_W = EXP_W + 2,
  localparam int OP_W   = 1 + OEXP_W + FRAC_W + 1
) (
  input  logic [WORD_W-1:0] word,
  input  logic              flush,
  output logic [OP_W-1:0]   op_out,
  output logic              denorm
);
  logic              sgn;
  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;

  assign sgn    = word[WORD_W-1];
  assign ex     = word[WORD_W-2:FRAC_W];
  assign fr     = word[FRAC_W-1:0];
  assign denorm = (ex == '0) && (fr != '0);

  always_comb begin
    if (ex != '0)
      op_out = {sgn, 2'b00, ex, 1'b1, fr};
    else if (fr == '0 || flush)
      op_out = {sgn, {(OP_W-1){1'b0}}};
    else
      op_out = {sgn, OEXP_W'(1), 1'b0, fr};
  end
endmodule

// File: rtl/dn_normalize.sv
// Moves the leading one of a subnormal fraction to the hidden-bit position.
module dn_normalize #(
  parameter int FRAC_W = 23,
  parameter int OEXP_W = 10,
  localparam int LZ_W  = $clog2(FRAC_W + 1),
  localparam int MANT_W = FRAC_W + 1,
  localparam int OP_W  = 1 + OEXP_W + MANT_W
) (
  input  logic              sign,
  input  logic [FRAC_W-1:0] frac,
  output logic [OP_W-1:0]   op_out
);
  logic [LZ_W-1:0]   lz;
  logic              found;
  logic [MANT_W-1:0] mant;
  logic [OEXP_W-1:0] exp_v;

  always_comb begin
    lz    = '0;
    found = 1'b0;
    for (int i = FRAC_W - 1; i >= 0; i--) begin
      if (!found) begin
        if (frac[i]) found = 1'b1;
        else         lz    = lz + LZ_W'(1);
      end
    end
  end

  assign mant   = {1'b0, frac} << (lz + LZ_W'(1));
  assign exp_v  = OEXP_W'(0) - OEXP_W'(lz);
  assign op_out = {sign, exp_v, mant};
endmodule

// File: rtl/dn_seq_ctrl.sv
// Stall sequencer: entry cycle, then one cycle per counted operand, first before second.
module dn_seq_ctrl
  import denorm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [1:0] need,
  output seq_state_t state,
  output logic       in_ready,
  output logic       busy,
  output logic       done
);
  seq_state_t nxt;
  logic [1:0] need_q;
  logic       done_d;

  always_comb begin
    nxt    = state;
    done_d = 1'b0;
    unique case (state)
      S_IDLE:
        if (accept) begin
          if (|need) nxt = S_ENTRY;
          else       done_d = 1'b1;
        end
      S_ENTRY:  nxt = need_q[0] ? S_NORM_A : S_NORM_B;
      S_NORM_A:
        if (need_q[1]) nxt = S_NORM_B;
        else begin
          nxt    = S_IDLE;
          done_d = 1'b1;
        end
      S_NORM_B: begin
        nxt    = S_IDLE;
        done_d = 1'b1;
      end
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      done   <= 1'b0;
      need_q <= '0;
    end else begin
      state <= nxt;
      done  <= done_d;
      if (accept) need_q <= need;
    end
  end

  assign in_ready = (state == S_IDLE);
  assign busy     = !in_ready;
endmodule

// File: rtl/dn_result_filter.sv
// Result path: subnormal results become signed zero in flush mode.
module dn_result_filter #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic              flush,
  input  logic [WORD_W-1:0] res_in,
  output logic [WORD_W-1:0] res_out
);
  logic zero_exp;
  assign zero_exp = (res_in[WORD_W-2:FRAC_W] == '0);
  assign res_out  = (flush && zero_exp) ? {res_in[WORD_W-1], {(WORD_W-1){1'b0}}} : res_in;
endmodule

// File: rtl/denorm_seq.sv
module denorm_seq
  import denorm_pkg::*;
#(
  parameter int EXP_W  = SP_EXP_W,
  parameter int FRAC_W = SP_FRAC_W,
  localparam int WORD_W = 1 + EXP_W + FRAC_W,
  localparam int OEXP_W = EXP_W + 2,
  localparam int OP_W   = 1 + OEXP_W + FRAC_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] opa_word,
  input  logic [WORD_W-1:0] opb_word,
  input  logic              op_mul,
  input  logic              opa_ext,
  input  logic              opb_ext,
  input  logic              ftz_mode,
  output logic              busy,
  output logic              done,
  output logic [OP_W-1:0]   opa_out,
  output logic [OP_W-1:0]   opb_out,
  input  logic [WORD_W-1:0] res_in,
  output logic [WORD_W-1:0] res_out
);
  localparam int LANES = 2;

  logic [WORD_W-1:0] word_in [LANES];
  logic [OP_W-1:0]   prep_op [LANES];
  logic [LANES-1:0]  ext_in, is_den, need;
  logic              accept;
  seq_state_t        state;

  logic [LANES-1:0]  raw_sign;
  logic [FRAC_W-1:0] raw_frac [LANES];
  logic              norm_sign;
  logic [FRAC_W-1:0] norm_frac;
  logic [OP_W-1:0]   norm_op;

  assign word_in[0] = opa_word;
  assign word_in[1] = opb_word;
  assign ext_in     = {opb_ext, opa_ext};
  assign accept     = in_valid && in_ready;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dn_operand_prep #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_prep (
      .word   (word_in[g]),
      .flush  (ftz_mode),
      .op_out (prep_op[g]),
      .denorm (is_den[g])
    );
    // an add with an operand already in extended form skips its extra cycle
    assign need[g] = !ftz_mode && is_den[g] && (op_mul || !ext_in[g]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        raw_sign[g] <= 1'b0;
        raw_frac[g] <= '0;
      end else if (accept) begin
        raw_sign[g] <= word_in[g][WORD_W-1];
        raw_frac[g] <= word_in[g][FRAC_W-1:0];
      end
    end
  end

  dn_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .need     (need),
    .state    (state),
    .in_ready (in_ready),
    .busy     (busy),
    .done     (done)
  );

  // one shared normalizer, steered to whichever operand the sequencer is on
  assign norm_sign = (state == S_NORM_B) ? raw_sign[1] : raw_sign[0];
  assign norm_frac = (state == S_NORM_B) ? raw_frac[1] : raw_frac[0];

  dn_normalize #(.FRAC_W(FRAC_W), .OEXP_W(OEXP_W)) u_norm (
    .sign   (norm_sign),
    .frac   (norm_frac),
    .op_out (norm_op)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_out <= '0;
      opb_out <= '0;
    end else if (accept) begin
      opa_out <= prep_op[0];
      opb_out <= prep_op[1];
    end else if (state == S_NORM_A) begin
      opa_out <= norm_op;
    end else if (state == S_NORM_B) begin
      opb_out <= norm_op;
    end
  end

  dn_result_filter #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_resf (
    .flush   (ftz_mode),
    .res_in  (res_in),
    .res_out (res_out)
  );
endmodule

// File: rtl/dn_seq_checker.sv
module dn_seq_checker #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] opa_word,
  input logic [WORD_W-1:0] opb_word,
  input logic              op_mul,
  input logic              opa_ext,
  input logic              opb_ext,
  input logic              ftz_mode,
  input logic              busy,
  input logic              done,
  input logic [WORD_W-1:0] res_in,
  input logic [WORD_W-1:0] res_out
);
  function automatic logic plain_word(input logic [WORD_W-1:0] w);
    return (w[WORD_W-2:FRAC_W] != '0) || (w[FRAC_W-1:0] == '0);
  endfunction

  logic take;
  assign take = in_valid && in_ready;

  a_r2_flush_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ftz_mode) |=> (done && !busy));

  a_r7_plain_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (take && plain_word(opa_word) && plain_word(opb_word)) |=> (done && !busy));

  a_r6_ext_add_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !op_mul && opa_ext && opb_ext) |=> done);

  a_r4_stall_at_least_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);

  a_r4_done_ends_stall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  a_r9_no_ready_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  a_r3_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    res_out[WORD_W-1] == res_in[WORD_W-1]);

  a_r3_ieee_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !ftz_mode |-> (res_out == res_in));

  a_r3_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ftz_mode && res_in[WORD_W-2:FRAC_W] == '0) |-> (res_out[WORD_W-2:0] == '0));
endmodule

bind denorm_seq dn_seq_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .opa_word (opa_word),
  .opb_word (opb_word),
  .op_mul   (op_mul),
  .opa_ext  (opa_ext),
  .opb_ext  (opb_ext),
  .ftz_mode (ftz_mode),
  .busy     (busy),
  .done     (done),
  .res_in   (res_in),
  .res_out  (res_out)
);

// File: tb/tb_denorm_seq.sv
`timescale 1ns/1ps
module tb_denorm_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] opa_word = '0, opb_word = '0;
  logic        op_mul = 1'b0, opa_ext = 1'b0, opb_ext = 1'b0, ftz_mode = 1'b0;
  logic        busy, done;
  logic [34:0] opa_out, opb_out;
  logic [31:0] res_in = '0, res_out;

  always #4 clk = ~clk;

  denorm_seq dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .opa_word(opa_word), .opb_word(opb_word), .op_mul(op_mul),
    .opa_ext(opa_ext), .opb_ext(opb_ext), .ftz_mode(ftz_mode),
    .busy(busy), .done(done), .opa_out(opa_out), .opb_out(opb_out),
    .res_in(res_in), .res_out(res_out)
  );

  int    vectors = 0, fails = 0;
  bit    finished = 1'b0;
  bit    checks_on = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, expv, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  function automatic logic [34:0] ref_op(input logic [31:0] w, input bit ftz, input bit exempt);
    logic [23:0] m;
    int          ex;
    if (w[30:23] != 0) return {w[31], 2'b00, w[30:23], 1'b1, w[22:0]};
    if (w[22:0] == 0 || ftz) return {w[31], 34'b0};
    if (exempt) return {w[31], 10'd1, 1'b0, w[22:0]};
    m  = {1'b0, w[22:0]};
    ex = 1;
    while (!m[23]) begin
      m = m << 1;
      ex--;
    end
    return {w[31], 10'(ex), m};
  endfunction

  function automatic string ref_tag(input logic [31:0] w, input bit ftz, input bit exempt);
    if (w[30:23] != 0) return "R8";
    if (w[22:0] == 0)  return "R7";
    if (ftz)           return "R1";
    if (exempt)        return "R6";
    return "R5";
  endfunction

  function automatic bit counted(input logic [31:0] w, input bit ftz, input bit exempt);
    return !ftz && w[30:23] == 0 && w[22:0] != 0 && !exempt;
  endfunction

  int          m_left = 0;
  bit          m_done = 1'b0;
  logic [34:0] m_a = '0, m_b = '0;
  string       m_tag_a = "R8", m_tag_b = "R8", m_tag_t = "R2";

  always @(posedge clk) begin
    bit ea, eb, ca, cb;
    int n;
    if (!rst_n) begin
      m_left = 0;
      m_done = 1'b0;
    end else if (m_left > 0) begin
      m_left--;
      m_done = (m_left == 0);
    end else if (in_valid) begin
      ea = !op_mul && opa_ext;
      eb = !op_mul && opb_ext;
      ca = counted(opa_word, ftz_mode, ea);
      cb = counted(opb_word, ftz_mode, eb);
      n  = int'(ca) + int'(cb);
      m_a = ref_op(opa_word, ftz_mode, ea);
      m_b = ref_op(opb_word, ftz_mode, eb);
      m_tag_a = ref_tag(opa_word, ftz_mode, ea);
      m_tag_b = ref_tag(opb_word, ftz_mode, eb);
      m_tag_t = (n == 2) ? "R10" : (n == 1) ? "R4" : ftz_mode ? "R2" : "R7";
      if (n == 0) m_done = 1'b1;
      else begin
        m_left = 1 + n;
        m_done = 1'b0;
      end
    end else begin
      m_done = 1'b0;
    end
  end

  // compare everything on the falling edge
  always @(negedge clk) begin
    logic [31:0] rexp;
    if (checks_on) begin
      chk(busy === (m_left > 0), m_tag_t, "busy", 64'(busy), 64'(m_left > 0));
      chk(done === m_done, m_tag_t, "done", 64'(done), 64'(m_done));
      chk(in_ready === (m_left == 0), "R9", "in_ready", 64'(in_ready), 64'(m_left == 0));
      if (m_done) begin
        chk(opa_out === m_a, m_tag_a, "opa_out", 64'(opa_out), 64'(m_a));
        chk(opb_out === m_b, m_tag_b, "opb_out", 64'(opb_out), 64'(m_b));
      end
      rexp = (ftz_mode && res_in[30:23] == 0) ? {res_in[31], 31'b0} : res_in;
      chk(res_out === rexp, "R3", "res_out", 64'(res_out), 64'(rexp));
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input logic [31:0] a, input logic [31:0] b, input bit mul,
                       input bit xa, input bit xb, input bit ftz);
    while (!in_ready) @(negedge clk);
    #1;
    opa_word = a; opb_word = b; op_mul = mul;
    opa_ext = xa; opb_ext = xb; ftz_mode = ftz;
    in_valid = 1'b1;
    @(negedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (5) @(negedge clk);
  endtask

  function automatic logic [31:0] rand_word();
    logic [22:0] f;
    f = 23'($urandom);
    case ($urandom % 5)
      0: return {1'($urandom), 8'd0, (f == 0) ? 23'd1 : f};
      1: return {1'($urandom), 8'd0, 23'd0};
      2: return {1'($urandom), 8'd0, 23'(f >> ($urandom % 23)) | 23'd1};
      3: return {1'($urandom), 8'd255, f};
      default: return {1'($urandom), 8'(1 + ($urandom % 254)), f};
    endcase
  endfunction

  initial begin : res_driver
    forever begin
      @(negedge clk); #1;
      case ($urandom % 3)
        0: res_in = {1'($urandom), 8'd0, 23'($urandom)};
        1: res_in = {1'($urandom), 31'd0};
        default: res_in = $urandom;
      endcase
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (4) @(negedge clk);
    // reset state, R4 / R9
    chk(busy === 1'b0 && done === 1'b0, "R4", "reset busy/done", 64'({busy, done}), 64'(0));
    chk(in_ready === 1'b1, "R9", "reset in_ready", 64'(in_ready), 64'(1));
    #1 rst_n = 1'b1;
    checks_on = 1'b1;
    @(negedge clk);

    issue(32'h3f80_0000, 32'hc000_0000, 1'b0, 1'b0, 1'b0, 1'b0); drain(); // R8 normals
    issue(32'h0000_0400, 32'h3f80_0000, 1'b1, 1'b0, 1'b0, 1'b0); drain(); // R4 R5 first only
    issue(32'h4000_0000, 32'h8040_0000, 1'b1, 1'b0, 1'b0, 1'b0); drain(); // R4 second only
    issue(32'h0000_0001, 32'h807f_ffff, 1'b1, 1'b0, 1'b0, 1'b0); drain(); // R10 R5 extremes
    issue(32'h8000_0003, 32'h0012_3456, 1'b0, 1'b0, 1'b0, 1'b1); drain(); // R1 R2 flush
    issue(32'h0000_0005, 32'h8000_0100, 1'b0, 1'b1, 1'b1, 1'b0); drain(); // R6 both exempt
    issue(32'h0000_0005, 32'h8000_0100, 1'b0, 1'b1, 1'b0, 1'b0); drain(); // R6 a exempt, b counted
    issue(32'h0000_0005, 32'h8000_0100, 1'b1, 1'b1, 1'b1, 1'b0); drain(); // R6 flag ignored on mul
    issue(32'h8000_0000, 32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0); drain(); // R7 signed zeros

    // R9: valid held high with changing operands during the stall
    while (!in_ready) @(negedge clk);
    #1;
    opa_word = 32'h0000_00ff; opb_word = 32'h0000_0010; op_mul = 1'b1;
    opa_ext = 1'b0; opb_ext = 1'b0; ftz_mode = 1'b0; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      opa_word = 32'h4040_0000 + k; opb_word = 32'h8000_0000;
    end
    @(negedge clk); #1;
    in_valid = 1'b0;
    drain();

    // random mix with random idle gaps
    for (int t = 0; t < 600; t++) begin
      issue(rand_word(), rand_word(), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
      repeat ($urandom % 3) @(negedge clk);
    end
    drain();

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule